// File: doc/BRIEF.md
# Light Sensor Register Target over I2C

This block is the host-facing register file of a colour light sensor. It sits on a two-wire I2C bus as a target at the fixed 7-bit address 0x38 and gives the host byte-wide access to configuration, status and result registers. The first byte of every write transfer loads a register pointer. Each data byte that follows is stored at the pointer, and the pointer then advances. To read, the host writes the pointer, issues a repeated START and the address with the read bit set, and clocks out as many bytes as it wants. It ACKs every byte except the last, which it NACKs.

Inside the chip the block presents every configuration field as a plain output. It takes five 16-bit measurement results (red, green, blue, white, infrared) and two status inputs from the sensing logic. SCL and SDA are oversampled by a much faster system clock. SDA is only ever pulled low, through an output-enable.

Top module: `lsens_i2c_regs`

## Requirements
- R1: The target ACKs an address byte whose upper seven bits equal 0x38 and leaves SDA released (NACK) for any other address. After a NACKed address it ignores the bus until the next START.
- R2: In a write transfer, the byte after the address is the register pointer. Each further byte is stored in the register the pointer selects and is ACKed.
- R3: The pointer advances by one after every data byte, both in multi-byte writes and in multi-byte reads.
- R4: After a pointer write, a repeated START and an address with the read bit set (bit 0 = 1) make the target return register contents MSB first. A host NACK ends the read, and SDA stays released afterwards.
- R5: After reset, the registers read as follows: 0x01 = 0x03, 0x0B = 0x11, 0x0E = 0xFF, 0x0F = 0xFF, 0x16 = 0x08, and 0x00, 0x03, 0x04, 0x05, 0x0C, 0x0D, 0x17 = 0x00. Register 0x02 reads 0x80, because its bit 7 (power-on flag) is set by reset.
- R6: Writes to the result and ID registers or to unmapped addresses are ACKed and change nothing. Unmapped addresses read 0x00.
- R7: Address 0xBC reads 0x12 and address 0xBD reads 0x07, whatever was written to them.
- R8: Addresses 0x1C to 0x25 hold the channel results as low/high byte pairs, in the order red, green, blue, white, infrared, with the low byte at the even address. Reading a low byte captures the matching high byte, so a later high-byte read returns the same sample even if the input has changed in between.
- R9: Writing a byte with bit 7 set to register 0x00 returns every register to its reset value and sets bit 7 of 0x02. Bit 7 of 0x00 then reads back 0.
- R10: In register 0x02, bit 7 and bit 0 are cleared by writing 0 to them and are unchanged by writing 1. Bit 6 always shows the data-invalid input and cannot be written.
- R11: A high level on the interrupt-set input sets bit 0 of 0x02. When it coincides with a host write that clears that bit, the set wins.
- R12: The configuration outputs follow their registers. The low threshold is {0x0D,0x0C}, the high threshold is {0x0F,0x0E}, and the single-byte fields map to 0x00, 0x01, 0x03, 0x04, 0x05, 0x0B, 0x16 and 0x17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| cls_set_i | input | 1 | Sets the light interrupt flag while high |
| data_bad_i | input | 1 | Data-invalid status shown in 0x02 bit 6 |
| ch_data_i | input | 80 | Five 16-bit results, red in bits 15:0 up to infrared in bits 79:64 |
| ctrl_o | output | 8 | Register 0x00 |
| intctl_o | output | 8 | Register 0x01 |
| wait_o | output | 8 | Register 0x03 |
| gain_o | output | 8 | Register 0x04 |
| itime_o | output | 8 | Register 0x05 |
| persist_o | output | 8 | Register 0x0B |
| thr_lo_o | output | 16 | Low threshold {0x0D,0x0C} |
| thr_hi_o | output | 16 | High threshold {0x0F,0x0E} |
| intsrc_o | output | 8 | Register 0x16 |
| errflag_o | output | 8 | Register 0x17 |
| por_flag_o | output | 1 | Power-on flag, 0x02 bit 7 |
| cls_flag_o | output | 1 | Light interrupt flag, 0x02 bit 0 |

## Verification
Two things can act on the light interrupt flag in the same clock: the internal set input and a host write of zero to register 0x02. The bench holds the set input high through an entire write transfer that clears the flag, so the write strobe is sure to fall inside the window where the set is active. It then reads 0x02 back over the bus and expects bit 0 still set. A second, uncontested clearing write must then drop it. The same kind of overlap between a low-byte capture and a changing channel input is judged by changing the input between the low-byte and high-byte reads.

// File: rtl/lsens_pkg.sv
package lsens_pkg;
  localparam logic [6:0] DEV_ADDR  = 7'h38;
  localparam int         NCFG      = 12;
  localparam int         NCH       = 5;
  localparam int         CHW       = 16;
  localparam logic [7:0] FLAG_ADDR = 8'h02;
  localparam logic [7:0] CH_BASE   = 8'h1C;
  localparam logic [7:0] ID_LO_ADR = 8'hBC;
  localparam logic [7:0] ID_HI_ADR = 8'hBD;
  localparam logic [7:0] ID_LO_VAL = 8'h12;
  localparam logic [7:0] ID_HI_VAL = 8'h07;

  // index: 0 ctrl, 1 intctl, 2 wait, 3 gain, 4 itime, 5 persist,
  //        6..9 thresholds (lo L/H, hi L/H), 10 intsrc, 11 err
  localparam logic [7:0] CFG_ADDR [NCFG] = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'h0B,
                                             8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h16, 8'h17};
  localparam logic [7:0] CFG_DEF  [NCFG] = '{8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 8'h11,
                                             8'h00, 8'h00, 8'hFF, 8'hFF, 8'h08, 8'h00};

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
  } link_st_t;
endpackage

// File: rtl/lsens_i2c_link.sv
module lsens_i2c_link
  import lsens_pkg::*;
#(
  parameter logic [6:0] ADDR = DEV_ADDR
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       ptr_ld,
  output logic       wr_en,
  output logic [7:0] wdata,
  output logic       rd_adv,
  input  logic [7:0] rdata
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d, scl_s, sda_s;
  logic       start_c, stop_c, rise, fall;

  link_st_t   st_q, st_n;
  logic [2:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic       oe_q, oe_n, ph_q, ph_n, hit_q, hit_n, rw_q, rw_n, first_q, first_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_sync[1];
      sda_d    <= sda_sync[1];
    end
  end

  assign scl_s   = scl_sync[1];
  assign sda_s   = sda_sync[1];
  assign start_c = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  assign rise    = scl_s & ~scl_d;
  assign fall    = ~scl_s & scl_d;
  assign wdata   = {sh_q[6:0], sda_s};
  assign sda_oe  = oe_q;

  always_comb begin
    st_n = st_q;  cnt_n = cnt_q;  sh_n = sh_q;  oe_n = oe_q;  ph_n = ph_q;
    hit_n = hit_q;  rw_n = rw_q;  first_n = first_q;
    ptr_ld = 1'b0;  wr_en = 1'b0;  rd_adv = 1'b0;
    if (start_c) begin
      st_n = ST_ADDR;  cnt_n = 3'd0;  oe_n = 1'b0;  first_n = 1'b1;
    end else if (stop_c) begin
      st_n = ST_IDLE;  oe_n = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: if (rise) begin
          sh_n  = wdata;
          cnt_n = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            st_n  = ST_AACK;  ph_n = 1'b0;
            hit_n = (sh_q[6:0] == ADDR);
            rw_n  = sda_s;
          end
        end
        ST_AACK: if (fall) begin
          if (!ph_q) begin
            if (hit_q) begin oe_n = 1'b1; ph_n = 1'b1; end
            else st_n = ST_IDLE;
          end else begin
            cnt_n = 3'd0;
            if (rw_q) begin
              st_n = ST_RBYTE;  sh_n = rdata;  oe_n = ~rdata[7];  rd_adv = 1'b1;
            end else begin
              st_n = ST_WBYTE;  oe_n = 1'b0;
            end
          end
        end
        ST_WBYTE: if (rise) begin
          sh_n  = wdata;
          cnt_n = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            st_n = ST_WACK;  ph_n = 1'b0;
            if (first_q) begin ptr_ld = 1'b1; first_n = 1'b0; end
            else wr_en = 1'b1;
          end
        end
        ST_WACK: if (fall) begin
          if (!ph_q) begin oe_n = 1'b1; ph_n = 1'b1; end
          else begin oe_n = 1'b0; st_n = ST_WBYTE; cnt_n = 3'd0; end
        end
        ST_RBYTE: if (fall) begin
          cnt_n = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            st_n = ST_RACK;  oe_n = 1'b0;  ph_n = 1'b0;
          end else begin
            sh_n = {sh_q[6:0], 1'b0};  oe_n = ~sh_q[6];
          end
        end
        ST_RACK: begin
          if (rise) begin
            if (sda_s) st_n = ST_IDLE;
            else ph_n = 1'b1;
          end else if (fall && ph_q) begin
            st_n = ST_RBYTE;  cnt_n = 3'd0;  sh_n = rdata;  oe_n = ~rdata[7];  rd_adv = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cnt_q <= 3'd0;  sh_q <= 8'h00;  oe_q <= 1'b0;  ph_q <= 1'b0;
      hit_q <= 1'b0;  rw_q <= 1'b0;  first_q <= 1'b0;
    end else begin
      st_q <= st_n;  cnt_q <= cnt_n;  sh_q <= sh_n;  oe_q <= oe_n;  ph_q <= ph_n;
      hit_q <= hit_n;  rw_q <= rw_n;  first_q <= first_n;
    end
  end

  // R1
  ack_only_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AACK && oe_q) |-> hit_q);

  // R4
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(oe_q) && !$past(start_c) && !$past(stop_c)) |-> !scl_s);
endmodule

// File: rtl/lsens_regbank.sv
module lsens_regbank
  import lsens_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ptr_ld,
  input  logic                wr_en,
  input  logic [7:0]          wdata,
  input  logic                rd_adv,
  output logic [7:0]          rdata,
  input  logic                cls_set_i,
  input  logic                data_bad_i,
  input  logic [NCH*CHW-1:0]  ch_data_i,
  output logic [NCFG*8-1:0]   cfg_flat,
  output logic                por_o,
  output logic                cls_o
);
  logic [7:0]       ptr_q, ptr_n;
  logic             swrst, flag_wr;
  logic             por_q, por_n, cls_q, cls_n;
  logic [NCH*8-1:0] hold_flat;

  assign swrst   = wr_en && (ptr_q == CFG_ADDR[0]) && wdata[7];
  assign flag_wr = wr_en && (ptr_q == FLAG_ADDR);

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    logic [7:0] r_q, r_n;
    always_comb begin
      r_n = r_q;
      if (swrst) r_n = CFG_DEF[i];
      else if (wr_en && (ptr_q == CFG_ADDR[i])) r_n = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= CFG_DEF[i];
      else        r_q <= r_n;
    end
    assign cfg_flat[i*8 +: 8] = r_q;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_hold
    logic [7:0] h_q;
    logic       cap;
    assign cap = rd_adv && (ptr_q == CH_BASE + 8'(2*k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   h_q <= 8'h00;
      else if (cap) h_q <= ch_data_i[k*CHW+8 +: 8];
    end
    assign hold_flat[k*8 +: 8] = h_q;
  end

  always_comb begin
    ptr_n = ptr_q;
    if (ptr_ld)               ptr_n = wdata;
    else if (wr_en || rd_adv) ptr_n = ptr_q + 8'd1;
    por_n = por_q;
    if (swrst)                     por_n = 1'b1;
    else if (flag_wr && !wdata[7]) por_n = 1'b0;
    cls_n = cls_q;
    if (swrst || (flag_wr && !wdata[0])) cls_n = 1'b0;
    if (cls_set_i)                       cls_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= 8'h00;  por_q <= 1'b1;  cls_q <= 1'b0;
    end else begin
      ptr_q <= ptr_n;  por_q <= por_n;  cls_q <= cls_n;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NCFG; i++)
      if (ptr_q == CFG_ADDR[i]) rdata = cfg_flat[i*8 +: 8];
    if (ptr_q == FLAG_ADDR) rdata = {por_q, data_bad_i, 5'b00000, cls_q};
    for (int k = 0; k < NCH; k++) begin
      if (ptr_q == CH_BASE + 8'(2*k))   rdata = ch_data_i[k*CHW +: 8];
      if (ptr_q == CH_BASE + 8'(2*k+1)) rdata = hold_flat[k*8 +: 8];
    end
    if (ptr_q == ID_LO_ADR) rdata = ID_LO_VAL;
    if (ptr_q == ID_HI_ADR) rdata = ID_HI_VAL;
  end

  assign por_o = por_q;
  assign cls_o = cls_q;

  // R9
  swrst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (cfg_flat[15:8] == 8'h03 && cfg_flat[7:0] == 8'h00 && por_q));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cls_set_i |=> cls_q);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_adv) && !ptr_ld) |=> (ptr_q == $past(ptr_q) + 8'd1));

  // R10
  por_write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && wdata[7]) |=> (por_q == $past(por_q)));
endmodule

// File: rtl/lsens_i2c_regs.sv
module lsens_i2c_regs
  import lsens_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          cls_set_i,
  input  logic          data_bad_i,
  input  logic [79:0]   ch_data_i,
  output logic [7:0]    ctrl_o,
  output logic [7:0]    intctl_o,
  output logic [7:0]    wait_o,
  output logic [7:0]    gain_o,
  output logic [7:0]    itime_o,
  output logic [7:0]    persist_o,
  output logic [15:0]   thr_lo_o,
  output logic [15:0]   thr_hi_o,
  output logic [7:0]    intsrc_o,
  output logic [7:0]    errflag_o,
  output logic          por_flag_o,
  output logic          cls_flag_o
);
  logic [1:0]        rst_sync;
  logic              rst_n_s;
  logic              ptr_ld, wr_en, rd_adv;
  logic [7:0]        wdata, rdata;
  logic [NCFG*8-1:0] cfg_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  lsens_i2c_link #(.ADDR(DEV_ADDR)) i_link (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe_o),
    .ptr_ld(ptr_ld), .wr_en(wr_en), .wdata(wdata), .rd_adv(rd_adv), .rdata(rdata)
  );

  lsens_regbank i_bank (
    .clk(clk), .rst_n(rst_n_s), .ptr_ld(ptr_ld), .wr_en(wr_en), .wdata(wdata),
    .rd_adv(rd_adv), .rdata(rdata), .cls_set_i(cls_set_i), .data_bad_i(data_bad_i),
    .ch_data_i(ch_data_i), .cfg_flat(cfg_flat), .por_o(por_flag_o), .cls_o(cls_flag_o)
  );

  assign ctrl_o    = cfg_flat[0*8 +: 8];
  assign intctl_o  = cfg_flat[1*8 +: 8];
  assign wait_o    = cfg_flat[2*8 +: 8];
  assign gain_o    = cfg_flat[3*8 +: 8];
  assign itime_o   = cfg_flat[4*8 +: 8];
  assign persist_o = cfg_flat[5*8 +: 8];
  assign thr_lo_o  = cfg_flat[6*8 +: 16];
  assign thr_hi_o  = cfg_flat[8*8 +: 16];
  assign intsrc_o  = cfg_flat[10*8 +: 8];
  assign errflag_o = cfg_flat[11*8 +: 8];
endmodule

// File: tb/test_lsens_i2c_regs.sv
module test_lsens_i2c_regs;
  localparam int CLK_P = 10;
  localparam int Q     = 8;

  logic clk, rst_n, host_scl, host_sda, sda_oe, cls_set, data_bad, sda_bus;
  logic [79:0] ch;
  logic [7:0] ctrl_o, intctl_o, wait_o, gain_o, itime_o, persist_o, intsrc_o, errflag_o;
  logic [15:0] thr_lo_o, thr_hi_o;
  logic por_o, cls_o;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  int nchk = 0, nerr = 0;

  assign sda_bus = host_sda & ~sda_oe;

  lsens_i2c_regs i_lsens_i2c_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .cls_set_i(cls_set), .data_bad_i(data_bad), .ch_data_i(ch),
    .ctrl_o(ctrl_o), .intctl_o(intctl_o), .wait_o(wait_o), .gain_o(gain_o),
    .itime_o(itime_o), .persist_o(persist_o), .thr_lo_o(thr_lo_o), .thr_hi_o(thr_hi_o),
    .intsrc_o(intsrc_o), .errflag_o(errflag_o), .por_flag_o(por_o), .cls_flag_o(cls_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input logic b);
    host_sda = b; hq(); host_scl = 1'b1; hq(); hq(); host_scl = 1'b0; hq();
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; hq(); host_scl = 1'b1; hq();
    @(negedge clk); b = sda_bus;
    hq(); host_scl = 1'b0; hq();
  endtask

  task automatic i2c_start();
    host_sda = 1'b1; hq(); host_scl = 1'b1; hq(); host_sda = 1'b0; hq(); host_scl = 1'b0; hq();
  endtask

  task automatic i2c_stop();
    host_sda = 1'b0; hq(); host_scl = 1'b1; hq(); host_sda = 1'b1; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(ack);
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(last);
  endtask

  task automatic wr_block(input logic [7:0] ptr, input int n);
    logic a;
    i2c_start();
    send_byte({7'h38, 1'b0}, a); chk("R1 address ack (write)", a, 0);
    send_byte(ptr, a);           chk("R2 pointer ack", a, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);     chk("R2 data ack", a, 0);
    end
    i2c_stop();
  endtask

  task automatic wr1(input logic [7:0] ptr, input logic [7:0] d);
    wbuf[0] = d;
    wr_block(ptr, 1);
  endtask

  task automatic rd_block(input logic [7:0] ptr, input int n);
    logic a;
    i2c_start();
    send_byte({7'h38, 1'b0}, a); chk("R1 address ack (pointer)", a, 0);
    send_byte(ptr, a);           chk("R4 pointer ack", a, 0);
    i2c_start();
    send_byte({7'h38, 1'b1}, a); chk("R4 address ack (read)", a, 0);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    i2c_stop();
    @(negedge clk);
    chk("R4 SDA released after NACK", sda_oe, 0);
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] ptr, input logic [7:0] exp);
    rd_block(ptr, 1);
    chk(tag, rbuf[0], exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R5 SDA idle after reset", sda_oe, 0);
    chk("R12 intctl_o default", intctl_o, 8'h03);
    chk("R12 thr_hi_o default", thr_hi_o, 16'hFFFF);
    chk("R12 persist_o default", persist_o, 8'h11);
    chk("R12 intsrc_o default", intsrc_o, 8'h08);
    chk_reg("R5 reg 0x00", 8'h00, 8'h00);
    chk_reg("R5 reg 0x01", 8'h01, 8'h03);
    chk_reg("R5 reg 0x02 por set", 8'h02, 8'h80);
    chk_reg("R5 reg 0x03", 8'h03, 8'h00);
    chk_reg("R5 reg 0x0B", 8'h0B, 8'h11);
    chk_reg("R5 reg 0x0C", 8'h0C, 8'h00);
    chk_reg("R5 reg 0x0E", 8'h0E, 8'hFF);
    chk_reg("R5 reg 0x0F", 8'h0F, 8'hFF);
    chk_reg("R5 reg 0x16", 8'h16, 8'h08);
    chk_reg("R5 reg 0x17", 8'h17, 8'h00);
  endtask

  task automatic t_addr();
    logic a;
    i2c_start();
    send_byte({7'h39, 1'b0}, a);
    chk("R1 wrong address NACK", a, 1);
    send_byte(8'h01, a);
    chk("R1 ignored until START", a, 1);
    i2c_stop();
    i2c_start();
    send_byte({7'h1C, 1'b1}, a);
    chk("R1 wrong read address NACK", a, 1);
    i2c_stop();
    chk_reg("R1 recovery read 0x01", 8'h01, 8'h03);
  endtask

  task automatic t_block();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_block(8'h0C, 4);
    @(negedge clk);
    chk("R12 thr_lo_o", thr_lo_o, 16'h2211);
    chk("R3 block write thr_hi_o", thr_hi_o, 16'h4433);
    rd_block(8'h0C, 4);
    chk("R3 block read byte0", rbuf[0], 8'h11);
    chk("R3 block read byte1", rbuf[1], 8'h22);
    chk("R3 block read byte2", rbuf[2], 8'h33);
    chk("R3 block read byte3", rbuf[3], 8'h44);
    wr1(8'h04, 8'h5A);
    @(negedge clk);
    chk("R2 gain_o single write", gain_o, 8'h5A);
    rd_block(8'h16, 3);
    chk("R3 read 0x16", rbuf[0], 8'h08);
    chk("R3 read 0x17", rbuf[1], 8'h00);
    chk("R6 unmapped 0x18 reads zero", rbuf[2], 8'h00);
  endtask

  task automatic t_readonly();
    wr1(8'h1C, 8'h55);
    chk_reg("R6 result reg not writable", 8'h1C, ch[7:0]);
    wr1(8'h06, 8'h77);
    chk_reg("R6 unmapped write ignored", 8'h06, 8'h00);
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    wr_block(8'hBC, 2);
    chk_reg("R7 id low", 8'hBC, 8'h12);
    chk_reg("R7 id high", 8'hBD, 8'h07);
  endtask

  task automatic t_channels();
    logic [15:0] v [5];
    v[0] = 16'h1234; v[1] = 16'h5678; v[2] = 16'h9ABC; v[3] = 16'hDEF0; v[4] = 16'h0F1E;
    ch = {v[4], v[3], v[2], v[1], v[0]};
    rd_block(8'h1C, 10);
    for (int k = 0; k < 5; k++) begin
      chk("R8 channel low byte", rbuf[2*k], v[k][7:0]);
      chk("R8 channel high byte", rbuf[2*k+1], v[k][15:8]);
    end
    chk_reg("R8 white low", 8'h22, 8'hF0);
    ch[63:48] = 16'hA55A;
    chk_reg("R8 white high from captured sample", 8'h23, 8'hDE);
    rd_block(8'h22, 2);
    chk("R8 new white low", rbuf[0], 8'h5A);
    chk("R8 new white high", rbuf[1], 8'hA5);
  endtask

  task automatic t_flags();
    data_bad = 1'b1;
    chk_reg("R10 data-invalid bit shown", 8'h02, 8'hC0);
    wr1(8'h02, 8'hFF);
    chk_reg("R10 writing ones has no effect", 8'h02, 8'hC0);
    wr1(8'h02, 8'h00);
    chk_reg("R10 por cleared by zero", 8'h02, 8'h40);
    @(posedge clk); #1 cls_set = 1'b1;
    @(posedge clk); #1 cls_set = 1'b0;
    @(negedge clk);
    chk("R11 cls_flag_o set", cls_o, 1);
    chk_reg("R11 flag bit0 set", 8'h02, 8'h41);
    wr1(8'h02, 8'h01);
    chk_reg("R10 bit0 kept by writing one", 8'h02, 8'h41);
    wr1(8'h02, 8'h00);
    chk_reg("R10 bit0 cleared by zero", 8'h02, 8'h40);
  endtask

  task automatic t_collide();
    @(posedge clk); #1 cls_set = 1'b1;
    wr1(8'h02, 8'h00);
    @(posedge clk); #1 cls_set = 1'b0;
    chk_reg("R11 set wins over clearing write", 8'h02, 8'h41);
    wr1(8'h02, 8'h00);
    chk_reg("R11 later clear works", 8'h02, 8'h40);
  endtask

  task automatic t_swreset();
    wr1(8'h01, 8'h00);
    wr1(8'h0B, 8'h55);
    wr1(8'h00, 8'h05);
    @(negedge clk);
    chk("R12 ctrl_o follows 0x00", ctrl_o, 8'h05);
    chk("R12 persist_o follows 0x0B", persist_o, 8'h55);
    wr1(8'h00, 8'h81);
    @(negedge clk);
    chk("R9 por_flag_o set", por_o, 1);
    chk("R9 thr_lo_o restored", thr_lo_o, 16'h0000);
    chk("R9 gain_o restored", gain_o, 8'h00);
    chk_reg("R9 ctrl reads zero", 8'h00, 8'h00);
    chk_reg("R9 intctl restored", 8'h01, 8'h03);
    chk_reg("R9 persist restored", 8'h0B, 8'h11);
    chk_reg("R9 flags after reset", 8'h02, 8'hC0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_scl = 1'b1; host_sda = 1'b1; cls_set = 1'b0; data_bad = 1'b0;
    ch = {16'h0F1E, 16'hDEF0, 16'h9ABC, 16'h5678, 16'h1234};
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    t_addr();
    t_block();
    t_readonly();
    t_channels();
    t_flags();
    t_collide();
    t_swreset();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule